// File: doc/BRIEF.md
# Six-Slot Rotating Priority Arbiter

This block picks one winner among six request lines. It searches the lines in a programmable order. A two-bit order selector chooses one of four search orders. Line 0 always leads every order and line 5 always closes it. The four middle lines take turns being searched first, so the selector only changes their relative rank.

Each line also has an in-use bit, and a line whose bit is clear is never chosen. The winner index and its valid flag are computed combinationally from the current requests and the registered selector.

The selector and a rotate-enable flag are registers that are loaded through a small write port. The caller raises a take strobe when it accepts the current winner. If rotate mode is on and a winner exists, the selector then steps by one at that clock edge and wraps from 3 to 0, which moves the next middle line to the front.

Top module: `rot_prio_arb`

## Requirements
- R1: With selector value s (0 to 3), the search order is line 0, then middle lines ((k-1+s) mod 4)+1 for k = 1 to 4, then line 5. This gives 0,1,2,3,4,5 for s=0; 0,2,3,4,1,5 for s=1; 0,3,4,1,2,5 for s=2; and 0,4,1,2,3,5 for s=3. The first usable requesting line in that order wins.
- R2: A usable request on line 0 always wins, and line 5 wins only when no other usable line requests, for every selector value.
- R3: A line whose in-use bit (slot_en_i bit n for line n, 1 = in use) is 0 never wins, even if it requests.
- R4: When no line is both requesting and in use, win_vld_o is 0 and win_idx_o is 7.
- R5: When rotate mode is on, and take_i and win_vld_o are both 1 at a clock edge with no load, sel_o becomes (sel_o+1) mod 4 after that edge. From 3 it wraps to 0.
- R6: When rotate mode is off, sel_o keeps its value across grants.
- R7: sel_o does not change at an edge where take_i is 0 or win_vld_o is 0.
- R8: A synchronous reset (rst_i high at a clock edge) clears the selector to 0 and turns rotate mode off.
- R9: When cfg_we_i is 1 at an edge, the selector takes cfg_sel_i and rotate mode takes cfg_rot_i. The load wins over a rotation in the same cycle.
- R10: win_idx_o and win_vld_o follow changes of req_i and slot_en_i within the same cycle, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| req_i | input | 6 | Request per line |
| slot_en_i | input | 6 | In-use bit per line, 1 = usable |
| cfg_we_i | input | 1 | Load strobe for selector and rotate flag |
| cfg_sel_i | input | 2 | Selector value to load |
| cfg_rot_i | input | 1 | Rotate-mode value to load |
| take_i | input | 1 | Caller accepts the current winner |
| win_idx_o | output | 3 | Winning line, 7 when none |
| win_vld_o | output | 1 | A winner exists |
| sel_o | output | 2 | Current selector value |

## Verification
The vector table covers all four selector values on patterns chosen to catch a wrong rotation of the middle lines. A design that rotated lines 0 or 5, or that used the wrong direction, would name a different middle line as the winner. Disabled lines that request are placed ahead of usable ones in the search order, so a design that ignored the in-use mask would report the disabled line.

The directed part looks at the selector register. It wraps from 3 to 0. It must not step on a take without a winner or on a winner without a take. A load and a rotation in the same cycle must resolve to the loaded value. After reset, rotate mode must be off, so a design that reset only the selector would show a step after reset.

// File: rtl/rpa_pkg.sv
`timescale 1ns/1ps
package rpa_pkg;
    localparam int NSLOT = 6;
    localparam int NMID  = NSLOT - 2;
    localparam int SEL_W = $clog2(NMID);
    localparam int IDX_W = $clog2(NSLOT);

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [IDX_W-1:0] idx_t;

    localparam idx_t IDX_NONE = '1;

    typedef struct packed {
        sel_t sel;
        logic rot;
    } arb_state_t;

    // Line searched at position pos for selector s; first and last are fixed.
    function automatic idx_t slot_at(input sel_t s, input int pos);
        int tmp;
        if (pos == 0) begin
            tmp = 0;
        end else if (pos == NSLOT - 1) begin
            tmp = NSLOT - 1;
        end else begin
            tmp = ((pos - 1 + int'(s)) % NMID) + 1;
        end
        return idx_t'(tmp);
    endfunction
endpackage

// File: rtl/rpa_order_map.sv
`timescale 1ns/1ps
module rpa_order_map
    import rpa_pkg::*;
(
    input  sel_t                          sel_i,
    output logic [NSLOT-1:0][IDX_W-1:0]   order_o
);
    for (genvar p = 0; p < NSLOT; p++) begin : g_pos
        assign order_o[p] = slot_at(sel_i, p);
    end
endmodule

// File: rtl/rpa_pick.sv
`timescale 1ns/1ps
module rpa_pick
    import rpa_pkg::*;
(
    input  logic [NSLOT-1:0][IDX_W-1:0] order_i,
    input  logic [NSLOT-1:0]            req_i,
    input  logic [NSLOT-1:0]            en_i,
    output idx_t                        win_idx_o,
    output logic                        win_vld_o
);
    logic [NSLOT-1:0] usable;
    logic [NSLOT-1:0] hit;

    assign usable = req_i & en_i;

    for (genvar p = 0; p < NSLOT; p++) begin : g_hit
        assign hit[p] = usable[order_i[p]];
    end

    always_comb begin
        win_idx_o = IDX_NONE;
        win_vld_o = 1'b0;
        for (int p = NSLOT - 1; p >= 0; p--) begin
            if (hit[p]) begin
                win_idx_o = order_i[p];
                win_vld_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rpa_sel_ctrl.sv
`timescale 1ns/1ps
module rpa_sel_ctrl
    import rpa_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic cfg_we_i,
    input  sel_t cfg_sel_i,
    input  logic cfg_rot_i,
    input  logic adv_i,
    output sel_t sel_o,
    output logic rot_o
);
    arb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we_i) begin
            st_d.sel = cfg_sel_i;
            st_d.rot = cfg_rot_i;
        end else if (st_q.rot && adv_i) begin
            st_d.sel = st_q.sel + sel_t'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{sel: '0, rot: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;
    assign rot_o = st_q.rot;

    assert_load_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        cfg_we_i |=> (sel_o == $past(cfg_sel_i)) && (rot_o == $past(cfg_rot_i)));

    assert_step_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cfg_we_i && adv_i && rot_o) |=> (sel_o == sel_t'($past(sel_o) + sel_t'(1))));

    assert_hold_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cfg_we_i && !rot_o) |=> $stable(sel_o));

    assert_noadv_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cfg_we_i && !adv_i) |=> $stable(sel_o));

    assert_reset_R8: assert property (@(posedge clk_i)
        rst_i |=> (sel_o == '0) && !rot_o);
endmodule

// File: rtl/rot_prio_arb.sv
`timescale 1ns/1ps
module rot_prio_arb
    import rpa_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [5:0]       req_i,
    input  logic [5:0]       slot_en_i,
    input  logic             cfg_we_i,
    input  logic [1:0]       cfg_sel_i,
    input  logic             cfg_rot_i,
    input  logic             take_i,
    output logic [2:0]       win_idx_o,
    output logic             win_vld_o,
    output logic [1:0]       sel_o
);
    sel_t                        sel_q;
    logic                        rot_q;
    logic [NSLOT-1:0][IDX_W-1:0] order;
    idx_t                        win_idx;
    logic                        win_vld;

    rpa_order_map u_map (
        .sel_i   (sel_q),
        .order_o (order)
    );

    rpa_pick u_pick (
        .order_i   (order),
        .req_i     (req_i),
        .en_i      (slot_en_i),
        .win_idx_o (win_idx),
        .win_vld_o (win_vld)
    );

    rpa_sel_ctrl u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .cfg_we_i  (cfg_we_i),
        .cfg_sel_i (cfg_sel_i),
        .cfg_rot_i (cfg_rot_i),
        .adv_i     (take_i && win_vld),
        .sel_o     (sel_q),
        .rot_o     (rot_q)
    );

    assign win_idx_o = win_idx;
    assign win_vld_o = win_vld;
    assign sel_o     = sel_q;

    assert_usable_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        win_vld_o |-> (req_i[win_idx_o] && slot_en_i[win_idx_o]));

    assert_none_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !win_vld_o |-> ((win_idx_o == 3'd7) && ((req_i & slot_en_i) == 6'd0)));

    assert_first_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i[0] && slot_en_i[0]) |-> (win_vld_o && win_idx_o == 3'd0));

    assert_last_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (win_vld_o && win_idx_o == 3'd5) |-> ((req_i[4:0] & slot_en_i[4:0]) == 5'd0));
endmodule

// File: tb/rot_prio_arb_tb.sv
`timescale 1ns/1ps
module rot_prio_arb_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] req = '0;
    logic [5:0] en  = '1;
    logic       we  = 1'b0;
    logic [1:0] csel = '0;
    logic       crot = 1'b0;
    logic       take = 1'b0;
    logic [2:0] widx;
    logic       wvld;
    logic [1:0] sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rot_prio_arb u_dut (
        .clk_i (clk), .rst_i (rst), .req_i (req), .slot_en_i (en),
        .cfg_we_i (we), .cfg_sel_i (csel), .cfg_rot_i (crot), .take_i (take),
        .win_idx_o (widx), .win_vld_o (wvld), .sel_o (sel)
    );

    // {sel[17:16], req[15:10], en[9:4], idx[3:1], vld[0]}
    localparam logic [17:0] VEC [0:12] = '{
        {2'd0, 6'b111111, 6'b111111, 3'd0, 1'b1},
        {2'd0, 6'b011110, 6'b111111, 3'd1, 1'b1},
        {2'd1, 6'b011110, 6'b111111, 3'd2, 1'b1},
        {2'd2, 6'b011110, 6'b111111, 3'd3, 1'b1},
        {2'd3, 6'b011110, 6'b111111, 3'd4, 1'b1},
        {2'd1, 6'b000010, 6'b111111, 3'd1, 1'b1},
        {2'd2, 6'b100110, 6'b111111, 3'd1, 1'b1},
        {2'd3, 6'b100100, 6'b111111, 3'd2, 1'b1},
        {2'd3, 6'b100000, 6'b111111, 3'd5, 1'b1},
        {2'd0, 6'b000001, 6'b111110, 3'd7, 1'b0},
        {2'd2, 6'b011000, 6'b110111, 3'd4, 1'b1},
        {2'd1, 6'b000000, 6'b111111, 3'd7, 1'b0},
        {2'd2, 6'b100001, 6'b111111, 3'd0, 1'b1}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load(input logic [1:0] s, input logic r);
        @(negedge clk);
        we = 1'b1; csel = s; crot = r;
        tick();
        we = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R8 reset selector", sel, 0);

        // Vector table: combinational winner per selector (R1 R2 R3 R4 R10)
        for (int i = 0; i < 13; i++) begin
            load(VEC[i][17:16], 1'b0);
            @(negedge clk);
            req = VEC[i][15:10];
            en  = VEC[i][9:4];
            #1;
            check($sformatf("R1 vec%0d sel", i), sel, VEC[i][17:16]);
            check($sformatf("R10 vec%0d idx", i), widx, VEC[i][3:1]);
            check($sformatf("R4 vec%0d vld", i), wvld, VEC[i][0]);
        end

        // Rotate off after reset: no stepping
        load(2'd0, 1'b0);
        @(negedge clk);
        rst = 1'b1; tick(); rst = 1'b0;
        en = '1; req = 6'b000010; take = 1'b1;
        tick();
        check("R8 rotate off after reset", sel, 0);
        check("R6 hold with rotate off", sel, 0);

        // Load with rotate, then step and wrap
        take = 1'b0;
        load(2'd2, 1'b1);
        check("R9 load selector", sel, 2);
        take = 1'b1;
        tick();
        check("R5 step 2->3", sel, 3);
        tick();
        check("R5 wrap 3->0", sel, 0);

        // No take: no step
        @(negedge clk);
        take = 1'b0;
        tick();
        check("R7 no take", sel, 0);
        // Take but no winner
        @(negedge clk);
        take = 1'b1; req = '0;
        #1;
        check("R4 no winner vld", wvld, 0);
        tick();
        check("R7 take without winner", sel, 0);

        // Load collides with rotation
        @(negedge clk);
        req = 6'b000010; take = 1'b1;
        we = 1'b1; csel = 2'd1; crot = 1'b1;
        tick();
        we = 1'b0;
        check("R9 load beats rotation", sel, 1);
        tick();
        check("R9 rotate flag loaded", sel, 2);

        // Rotate off via load: selector holds across grants
        take = 1'b0;
        load(2'd3, 1'b0);
        @(negedge clk);
        take = 1'b1;
        tick();
        tick();
        check("R6 hold across grants", sel, 3);

        // Reset from rotating state
        take = 1'b0;
        load(2'd1, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        check("R8 reset clears selector", sel, 0);
        @(negedge clk);
        take = 1'b1;
        tick();
        check("R8 reset clears rotate", sel, 0);

        // Disabled line ahead in order is skipped
        @(negedge clk);
        take = 1'b0; req = 6'b000011; en = 6'b111110;
        #1;
        check("R3 disabled line 0 skipped", widx, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule